// File: doc/BRIEF.md
# Emulated Tri-State Bus Resolver

This block stands in for a shared on-chip bus that would otherwise use tri-state drivers. Each of N sources presents a data word and its own enable bit. The block merges them into one bus value using only multiplexing logic, so no high-impedance value ever exists inside the design. The result is fully defined for every enable pattern. If exactly one source is enabled, the bus carries that source's word. If two or more sources are enabled at once, the bus goes to all zeros. If no source is enabled, the bus goes to all ones.

Two flags report the abnormal cases, for debugging. One flag marks a clash between drivers and the other marks a bus that nobody drives. A parameter chooses between a purely combinational path and a registered output. The registered output adds one clock of latency and has a synchronous active-low reset. Arbitration and grant logic are left to the surrounding design.

Top module: `tsbus_resolver`

## Requirements
- R1: If exactly one bit of `drv_en` is high, say bit i, `bus_out` equals source word i unchanged. Word i occupies bits `[i*W +: W]` of `drv_data`, and bit i of `drv_en` is its enable.
- R2: If two or more bits of `drv_en` are high, `bus_out` is all zeros, whatever the data words are.
- R3: If no bit of `drv_en` is high, `bus_out` is all ones.
- R4: `contend_flag` is 1 exactly when two or more enables are high, and 0 otherwise.
- R5: `float_flag` is 1 exactly when all enables are low. `contend_flag` and `float_flag` are never 1 together.
- R6: With `REG_OUT`=1, the outputs show the resolution of the inputs sampled at the previous rising clock edge. With `REG_OUT`=0, they follow the inputs within the same cycle.
- R7: With `REG_OUT`=1, holding `rst_n` low through a rising edge makes `bus_out` all ones, `float_flag` 1 and `contend_flag` 0 after that edge.
- R8: With `REG_OUT`=0, `rst_n` and `clk` have no effect: the outputs still follow R1 to R5 while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| drv_en | input | N | One enable bit per source |
| drv_data | input | N*W | Source words, word i at bits [i*W +: W] |
| bus_out | output | W | Resolved bus value |
| contend_flag | output | 1 | Two or more sources enabled |
| float_flag | output | 1 | No source enabled |

## Verification
The bench builds two copies of the block. The first is combinational, with N=4 and W=8. It is swept through all 16 enable patterns under four data patterns, including all-zero and all-one words. Those words make a single enabled driver look like the contention and float values on the bus, so only the flags tell the cases apart. The second copy is registered, with N=3 and W=5. It exposes the one-cycle latency, the reset value of the register, and word slicing at an odd width. Reset is also pulsed in the middle of the sweep: the combinational copy must ignore it while the registered copy must return to its reset value.

// File: rtl/tsbus_pkg.sv
// Package: types shared by the bus resolver modules.
// Assumes: nothing beyond IEEE 1800-2017.
package tsbus_pkg;

    // Classification of an enable pattern.
    typedef enum logic [1:0] {
        RK_FLOAT   = 2'd0,
        RK_SINGLE  = 2'd1,
        RK_CONTEND = 2'd2
    } res_kind_e;

endpackage

// File: rtl/tsbus_en_classify.sv
// Module: sorts an enable vector into no driver, one driver, or several.
// Assumes: N >= 1. A linear prefix scan tracks "one seen" and "two seen".
module tsbus_en_classify
    import tsbus_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] en,
    output res_kind_e    kind
);

    logic [N:0] seen_one;
    logic [N:0] seen_two;

    assign seen_one[0] = 1'b0;
    assign seen_two[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_scan
        // Advance the scan by one enable bit.
        assign seen_one[i+1] = seen_one[i] | en[i];
        assign seen_two[i+1] = seen_two[i] | (seen_one[i] & en[i]);
    end

    // Map the scan result to a classification.
    always_comb begin
        if (seen_two[N]) begin
            kind = RK_CONTEND;
        end else if (seen_one[N]) begin
            kind = RK_SINGLE;
        end else begin
            kind = RK_FLOAT;
        end
    end

endmodule

// File: rtl/tsbus_data_merge.sv
// Module: AND-OR merge of all enabled source words.
// Assumes: the result is meaningful only when exactly one enable is high;
// the caller overrides the other cases.
module tsbus_data_merge #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic [N*W-1:0] data,
    input  logic [N-1:0]   en,
    output logic [W-1:0]   merged
);

    logic [W-1:0] acc [N+1];

    assign acc[0] = '0;

    for (genvar i = 0; i < N; i++) begin : g_merge
        // Gate word i by its enable and fold it into the running OR.
        assign acc[i+1] = acc[i] | (data[i*W +: W] & {W{en[i]}});
    end

    assign merged = acc[N];

endmodule

// File: rtl/tsbus_out_stage.sv
// Module: optional output register for the resolved bus and its flags.
// Assumes: REG_OUT=1 registers with a synchronous active-low reset to the
// undriven-bus value; REG_OUT=0 passes through and ignores clk and rst_n.
module tsbus_out_stage #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bus_d,
    input  logic         contend_d,
    input  logic         float_d,
    output logic [W-1:0] bus_q,
    output logic         contend_q,
    output logic         float_q
);

    if (REG_OUT) begin : g_reg
        // Capture the resolved value; reset to the undriven-bus state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bus_q     <= '1;
                contend_q <= 1'b0;
                float_q   <= 1'b1;
            end else begin
                bus_q     <= bus_d;
                contend_q <= contend_d;
                float_q   <= float_d;
            end
        end
    end else begin : g_pass
        assign bus_q     = bus_d;
        assign contend_q = contend_d;
        assign float_q   = float_d;
    end

endmodule

// File: rtl/tsbus_resolver.sv
// Module: top of the emulated tri-state bus resolver.
// Assumes: N >= 1 and W >= 1. Contention resolves to all zeros, an idle bus
// to all ones, and a single driver passes through unchanged.
module tsbus_resolver
    import tsbus_pkg::*;
#(
    parameter int N       = 4,
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   drv_en,
    input  logic [N*W-1:0] drv_data,
    output logic [W-1:0]   bus_out,
    output logic           contend_flag,
    output logic           float_flag
);

    localparam int DATA_BITS = N * W;

    res_kind_e              kind;
    logic [W-1:0]           merged;
    logic [W-1:0]           bus_d;
    logic                   contend_d;
    logic                   float_d;
    logic [DATA_BITS-1:0]   data_in;

    assign data_in = drv_data;

    tsbus_en_classify #(.N(N)) u_classify (
        .en   (drv_en),
        .kind (kind)
    );

    tsbus_data_merge #(.N(N), .W(W)) u_merge (
        .data   (data_in),
        .en     (drv_en),
        .merged (merged)
    );

    // Apply the fixed resolution rules to the merged word.
    always_comb begin
        contend_d = (kind == RK_CONTEND);
        float_d   = (kind == RK_FLOAT);
        case (kind)
            RK_CONTEND: bus_d = '0;
            RK_FLOAT:   bus_d = '1;
            default:    bus_d = merged;
        endcase
    end

    tsbus_out_stage #(.W(W), .REG_OUT(REG_OUT)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_d     (bus_d),
        .contend_d (contend_d),
        .float_d   (float_d),
        .bus_q     (bus_out),
        .contend_q (contend_flag),
        .float_q   (float_flag)
    );

endmodule

// File: rtl/tsbus_resolver_chk.sv
// Module: assertion checker bound to tsbus_resolver.
// Assumes: inputs are stable around the rising clock edge.
module tsbus_resolver_chk #(
    parameter int N       = 4,
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   drv_en,
    input logic [N*W-1:0] drv_data,
    input logic [W-1:0]   bus_out,
    input logic           contend_flag,
    input logic           float_flag
);

    // Word of the highest enabled source (the only one when a single bit is set).
    function automatic logic [W-1:0] pick_word(input logic [N-1:0] en,
                                               input logic [N*W-1:0] data);
        logic [W-1:0] w;
        w = '0;
        for (int i = 0; i < N; i++) begin
            if (en[i]) w = data[i*W +: W];
        end
        return w;
    endfunction

    // R5: the two flags exclude each other.
    a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(contend_flag && float_flag));

    // R2: contention always shows all zeros on the bus.
    a_r2_contend_low: assert property (@(posedge clk) disable iff (!rst_n)
        contend_flag |-> (bus_out == '0));

    // R3: an undriven bus always shows all ones.
    a_r3_float_high: assert property (@(posedge clk) disable iff (!rst_n)
        float_flag |-> (bus_out == '1));

    if (REG_OUT) begin : g_reg_props
        // R1 and R6: a single driver appears one cycle later.
        a_r1_single_pass: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(drv_en) == 1) |=> (bus_out == $past(pick_word(drv_en, drv_data))));
        // R4: contention flag follows the count of enables with one cycle of delay.
        a_r4_contend_count: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (contend_flag == ($past($countones(drv_en)) > 1)));
        // R5: float flag follows an all-low enable vector with one cycle of delay.
        a_r5_float_idle: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (float_flag == ($past(drv_en) == '0)));
        // R7: the reset value of the register.
        a_r7_reset_value: assert property (@(posedge clk)
            !rst_n |=> (bus_out == '1 && float_flag && !contend_flag));
    end else begin : g_comb_props
        // R1 and R6: a single driver appears in the same cycle.
        a_r1_single_pass: assert property (@(posedge clk)
            ($countones(drv_en) == 1) |-> (bus_out == pick_word(drv_en, drv_data)));
        // R4 and R8: contention flag tracks the enables, even in reset.
        a_r4_contend_count: assert property (@(posedge clk)
            contend_flag == ($countones(drv_en) > 1));
        // R5 and R8: float flag tracks the enables, even in reset.
        a_r5_float_idle: assert property (@(posedge clk)
            float_flag == (drv_en == '0));
    end

endmodule

bind tsbus_resolver tsbus_resolver_chk #(.N(N), .W(W), .REG_OUT(REG_OUT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .drv_en       (drv_en),
    .drv_data     (drv_data),
    .bus_out      (bus_out),
    .contend_flag (contend_flag),
    .float_flag   (float_flag)
);

// File: tb/tsbus_resolver_bench.sv
// Bench: drives a combinational copy (N=4, W=8) and a registered copy
// (N=3, W=5) and compares both with a behavioural model on every clock.
module tsbus_resolver_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  en = '0;
    logic [31:0] data = '0;

    logic [7:0]  c_bus;
    logic        c_cont, c_flt;
    logic [4:0]  r_bus;
    logic        r_cont, r_flt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tsbus_resolver #(.N(4), .W(8), .REG_OUT(1'b0)) u_tsbus_resolver (
        .clk(clk), .rst_n(rst_n), .drv_en(en[3:0]), .drv_data(data),
        .bus_out(c_bus), .contend_flag(c_cont), .float_flag(c_flt));

    tsbus_resolver #(.N(3), .W(5), .REG_OUT(1'b1)) u_tsbus_resolver_reg (
        .clk(clk), .rst_n(rst_n), .drv_en(en[2:0]), .drv_data(data[14:0]),
        .bus_out(r_bus), .contend_flag(r_cont), .float_flag(r_flt));

    // Behavioural model: count the enables and pick the result from the count.
    function automatic void model(input int n, input int w, input logic [7:0] e,
                                  input logic [31:0] d, output logic [7:0] bus,
                                  output logic cont, output logic flt, output int cnt);
        int idx;
        cnt = 0;
        idx = 0;
        for (int i = 0; i < n; i++) begin
            if (e[i]) begin
                cnt++;
                idx = i;
            end
        end
        bus = '0;
        if (cnt == 0) begin
            for (int b = 0; b < w; b++) bus[b] = 1'b1;
        end else if (cnt == 1) begin
            for (int b = 0; b < w; b++) bus[b] = d[idx*w + b];
        end
        cont = (cnt > 1);
        flt  = (cnt == 0);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h time=%0t", req, act, exp, $time);
        end
    endtask

    // Combinational copy: checked shortly after each new input is applied.
    task automatic check_comb();
        logic [7:0] eb;
        logic ec, ef;
        int cnt;
        model(4, 8, en, data, eb, ec, ef, cnt);
        if (!rst_n)        check("R8 bus in reset", c_bus, eb);
        else if (cnt == 1) check("R1 single driver", c_bus, eb);
        else if (cnt == 0) check("R3 idle bus", c_bus, eb);
        else               check("R2 contention", c_bus, eb);
        check("R4 contend flag", {7'd0, c_cont}, {7'd0, ec});
        check("R5 float flag", {7'd0, c_flt}, {7'd0, ef});
    endtask

    // Registered copy: expected value pushed at each edge, compared after it.
    typedef struct packed { logic [7:0] bus; logic cont; logic flt; logic rst; } exp_t;
    exp_t exp_q[$];

    always @(posedge clk) begin
        exp_t x;
        int cnt;
        if (!rst_n) begin
            x.bus = 8'h1f; x.cont = 1'b0; x.flt = 1'b1; x.rst = 1'b1;
        end else begin
            model(3, 5, en, data, x.bus, x.cont, x.flt, cnt);
            x.rst = 1'b0;
        end
        exp_q.push_back(x);
        #2;
        if (!done && exp_q.size() > 0) begin
            x = exp_q.pop_front();
            if (x.rst) begin
                check("R7 reset bus", {3'd0, r_bus}, x.bus);
                check("R7 reset flags", {6'd0, r_cont, r_flt}, {6'd0, x.cont, x.flt});
            end else begin
                check("R6 registered bus", {3'd0, r_bus}, x.bus);
                check("R6 registered flags", {6'd0, r_cont, r_flt}, {6'd0, x.cont, x.flt});
            end
        end
    end

    function automatic logic [31:0] data_pattern(input int d);
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            case (d)
                0:       v[i*8 +: 8] = 8'((d * 73) + (i * 29) + 5);
                1:       v[i*8 +: 8] = 8'(8'h96 ^ (i * 51));
                2:       v[i*8 +: 8] = 8'h00;
                default: v[i*8 +: 8] = 8'hff;
            endcase
        end
        return v;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        for (int d = 0; d < 4; d++) begin
            for (int p = 0; p < 16; p++) begin
                @(posedge clk);
                #3 en = 8'(p);
                data = data_pattern(d);
                #1 check_comb();
            end
        end
        // Mid-run reset: R8 for the combinational copy, R7 for the registered one.
        for (int p = 0; p < 6; p++) begin
            @(posedge clk);
            #3 rst_n = (p >= 4);
            en = 8'(p * 3 + 1);
            data = data_pattern(p % 2);
            #1 check_comb();
        end
        repeat (2) @(posedge clk);
        #4 done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule